// File: doc/BRIEF.md
# Banked and Pointer-Indirect Data Memory Access Unit

This unit sits between the execution stage of a small 8-bit core and its data storage. It turns each data access into a select for one storage region. Direct accesses carry a 7-bit offset, and the active bank is prepended to it. Indirect accesses go through one of two 16-bit pointers. The regions are core registers, per-bank peripheral registers, per-bank general RAM, common RAM shared by all banks, and a read-only window onto program memory. The unit holds the bank select register and both pointers. These are reachable as core registers. The unit also contains a small behavioural model of the peripheral and RAM storage.

Each 128-byte bank is laid out as follows:

| Offsets | Region | Scope |
|---|---|---|
| 0x00 to 0x0B | core registers | the same registers in every bank |
| 0x0C to 0x1F | peripheral registers | one set per bank |
| 0x20 to 0x6F | general RAM | one set per bank |
| 0x70 to 0x7F | common RAM | shared by all banks |

An indirect access with pointer bit 15 clear addresses the data space with the pointer's low 12 bits. With bit 15 set, it reads the low byte of a 14-bit program word. That read costs one stall cycle, and writes through such a pointer are discarded. Read data is registered.

At most one access is performed per cycle. A direct strobe has priority over an indirect one. Every strobe presented during a stall cycle is dropped.

Top module: `dmx_access`

## Requirements
- R1: After reset the bank select register and both pointers read zero, `stall` is low and `rdata` is zero.
- R2: A direct access addresses bank `bsr` at offset `dir_addr`. A read strobe in cycle T puts the stored byte on `rdata` in cycle T+1. `rdata` holds its value in cycles with no read.
- R3: Offsets 0x00 to 0x0B are one set of core registers seen from every bank, laid out as follows:
  - 0x04 and 0x05 are the low and high bytes of pointer 0.
  - 0x06 and 0x07 are the low and high bytes of pointer 1.
  - 0x08 is the bank select register. It keeps only its low BANK_W bits, and its upper bits read as zero.
- R4: Offsets 0x70 to 0x7F are common RAM. A byte written there from any bank reads back the same from every other bank.
- R5: Peripheral offsets 0x0C to 0x1F exist only in banks below PER_BANKS. General RAM offsets 0x20 to 0x6F exist only in banks below GPR_BANKS. Unimplemented locations read zero and ignore writes.
- R6: An indirect access with pointer bit 15 clear addresses data location pointer[11:0], with bank = bits 11:7 and offset = bits 6:0. Any of pointer bits 14:12 set makes the location unimplemented.
- R7: An indirect read with pointer bit 15 set raises `stall` for exactly the one cycle after the strobe. `rdata` then carries bits 7:0 of the program word at the pointer value modulo 2^PROG_AW, in the cycle after the stall.
- R8: An indirect write with pointer bit 15 set changes no storage location and no register.
- R9: Every strobe presented while `stall` is high is ignored.
- R10: A write to the bank select register applies from the very next cycle's access onward.
- R11: When a direct and an indirect strobe arrive in the same cycle, only the direct access is performed, and it causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Offset within the active bank for a direct access |
| dir_rd | input | 1 | Direct read strobe |
| dir_wr | input | 1 | Direct write strobe |
| ind_rd | input | 1 | Indirect read strobe |
| ind_wr | input | 1 | Indirect write strobe |
| ind_sel | input | 1 | Pointer choice for an indirect access (0 or 1) |
| wdata | input | 8 | Write data |
| prog_word | input | PROG_DW | Program word at `prog_addr`, supplied combinationally |
| prog_addr | output | PROG_AW | Registered program memory word address |
| rdata | output | 8 | Registered read data |
| stall | output | 1 | High for the wait cycle of a program-memory read |

## Verification
The hardest case to reach is a strobe that arrives during the single stall cycle. It needs a pointer loaded with bit 15 set, then a read through it, then a direct write whose timing is exact to the cycle. The bench drives that write on the negative edge that falls inside the stall cycle. It then reads the target location back to show that the location is unchanged. A second hard case is a blocked program-memory write. The bench points the pointer so that its low bits alias a general RAM byte that already holds a known value. A write leak then shows up as a changed byte at an ordinary direct address.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   // Geometry of one bank
   localparam int OFS_W    = 7;
   localparam int PTR_W    = 16;
   localparam int CORE_N   = 12;
   localparam int PERI_N   = 20;
   localparam int GPR_N    = 80;
   localparam int COMMON_N = 16;

   // Region boundaries inside a bank (exclusive ends)
   localparam logic [OFS_W-1:0] CORE_END = 7'h0C;
   localparam logic [OFS_W-1:0] PERI_END = 7'h20;
   localparam logic [OFS_W-1:0] GPR_END  = 7'h70;

   // Core register slots held by this unit
   localparam logic [3:0] IX_P0_LO = 4'd4;
   localparam logic [3:0] IX_P0_HI = 4'd5;
   localparam logic [3:0] IX_P1_LO = 4'd6;
   localparam logic [3:0] IX_P1_HI = 4'd7;
   localparam logic [3:0] IX_BANK  = 4'd8;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CORE,
      RG_PERI,
      RG_GPR,
      RG_COMMON
   } region_e;

endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
   import dmx_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int PER_BANKS = 1,
   parameter int GPR_BANKS = 4
) (
   input  logic [BANK_W+OFS_W-1:0] addr,
   input  logic                    in_range,
   output region_e                 region,
   output logic [OFS_W-1:0]        idx,
   output logic [BANK_W-1:0]       bank
);

   localparam logic [BANK_W:0] PER_LIM = (BANK_W+1)'(PER_BANKS);
   localparam logic [BANK_W:0] GPR_LIM = (BANK_W+1)'(GPR_BANKS);

   logic [OFS_W-1:0] ofs;

   assign bank = addr[BANK_W+OFS_W-1:OFS_W];
   assign ofs  = addr[OFS_W-1:0];

   always_comb begin
      region = RG_NONE;
      idx    = ofs;
      if (in_range) begin
         if (ofs < CORE_END) begin
            region = RG_CORE;
         end else if (ofs < PERI_END) begin
            idx = ofs - CORE_END;
            if ({1'b0, bank} < PER_LIM) region = RG_PERI;
         end else if (ofs < GPR_END) begin
            idx = ofs - PERI_END;
            if ({1'b0, bank} < GPR_LIM) region = RG_GPR;
         end else begin
            idx    = ofs - GPR_END;
            region = RG_COMMON;
         end
      end
   end

endmodule

// File: rtl/dmx_core_regs.sv
module dmx_core_regs
   import dmx_pkg::*;
#(
   parameter int BANK_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        idx,
   input  logic [7:0]        wdata,
   output logic [7:0]        rd_data,
   output logic [BANK_W-1:0] bsr,
   output logic [PTR_W-1:0]  ptr0,
   output logic [PTR_W-1:0]  ptr1
);

   localparam logic [7:0] BANK_MASK = 8'((1 << BANK_W) - 1);

   logic [7:0] reg_q [CORE_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CORE_N; i++) reg_q[i] <= '0;
      end else if (wr_en && (idx < 4'(CORE_N))) begin
         reg_q[idx] <= (idx == IX_BANK) ? (wdata & BANK_MASK) : wdata;
      end
   end

   assign rd_data = (idx < 4'(CORE_N)) ? reg_q[idx] : 8'h00;
   assign bsr     = reg_q[IX_BANK][BANK_W-1:0];
   assign ptr0    = {reg_q[IX_P0_HI], reg_q[IX_P0_LO]};
   assign ptr1    = {reg_q[IX_P1_HI], reg_q[IX_P1_LO]};

endmodule

// File: rtl/dmx_store.sv
module dmx_store
   import dmx_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int PER_BANKS = 1,
   parameter int GPR_BANKS = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  region_e           region,
   input  logic [OFS_W-1:0]  idx,
   input  logic [BANK_W-1:0] bank,
   input  logic [7:0]        wdata,
   output logic [7:0]        rd_data
);

   logic [7:0] com_q [COMMON_N];
   logic [7:0] per_rd;
   logic [7:0] gpr_rd;

   always_ff @(posedge clk) begin
      if (wr_en && region == RG_COMMON) com_q[idx[3:0]] <= wdata;
   end

   if (PER_BANKS > 0) begin : g_peri
      localparam int PA_W = $clog2(PER_BANKS * PERI_N);
      logic [7:0]      per_q [PER_BANKS*PERI_N];
      logic [PA_W-1:0] pa;
      assign pa = PA_W'(int'(bank) * PERI_N + int'(idx));
      always_ff @(posedge clk) begin
         if (wr_en && region == RG_PERI) per_q[pa] <= wdata;
      end
      assign per_rd = per_q[pa];
   end else begin : g_no_peri
      assign per_rd = 8'h00;
   end

   if (GPR_BANKS > 0) begin : g_gpr
      localparam int GA_W = $clog2(GPR_BANKS * GPR_N);
      logic [7:0]      gpr_q [GPR_BANKS*GPR_N];
      logic [GA_W-1:0] ga;
      assign ga = GA_W'(int'(bank) * GPR_N + int'(idx));
      always_ff @(posedge clk) begin
         if (wr_en && region == RG_GPR) gpr_q[ga] <= wdata;
      end
      assign gpr_rd = gpr_q[ga];
   end else begin : g_no_gpr
      assign gpr_rd = 8'h00;
   end

   always_comb begin
      case (region)
         RG_PERI:   rd_data = per_rd;
         RG_GPR:    rd_data = gpr_rd;
         RG_COMMON: rd_data = com_q[idx[3:0]];
         default:   rd_data = 8'h00;
      endcase
   end

endmodule

// File: rtl/dmx_access.sv
module dmx_access
   import dmx_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int PER_BANKS = 1,
   parameter int GPR_BANKS = 4,
   parameter int PROG_AW   = 10,
   parameter int PROG_DW   = 14,
   parameter int DATA_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OFS_W-1:0]   dir_addr,
   input  logic               dir_rd,
   input  logic               dir_wr,
   input  logic               ind_rd,
   input  logic               ind_wr,
   input  logic               ind_sel,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [PROG_DW-1:0] prog_word,
   output logic [PROG_AW-1:0] prog_addr,
   output logic [DATA_W-1:0]  rdata,
   output logic               stall
);

   localparam int DA_W = BANK_W + OFS_W;

   // Elaboration-time parameter checks
   if (DATA_W != 8) begin : g_chk_dw
      $error("dmx_access: DATA_W must be 8");
   end
   if (DA_W > PTR_W - 1) begin : g_chk_da
      $error("dmx_access: data address does not fit below the program flag");
   end
   if (PROG_AW < 1 || PROG_AW > PTR_W - 1) begin : g_chk_pa
      $error("dmx_access: PROG_AW out of range");
   end
   if (PROG_DW < DATA_W) begin : g_chk_pd
      $error("dmx_access: program word narrower than data");
   end
   if (PER_BANKS > (1 << BANK_W) || GPR_BANKS > (1 << BANK_W)) begin : g_chk_bk
      $error("dmx_access: more implemented banks than addressable");
   end

   logic [BANK_W-1:0]  bsr;
   logic [PTR_W-1:0]   ptr0, ptr1, sel_ptr;
   logic               pm_pend_q;
   logic [PROG_AW-1:0] prog_addr_q;
   logic [DATA_W-1:0]  rdata_q;

   logic               dir_act, ind_act, ind_pm, in_range;
   logic               acc_wr, acc_rd, pm_start;
   logic [DA_W-1:0]    addr;
   region_e            region;
   logic [OFS_W-1:0]   idx;
   logic [BANK_W-1:0]  bank;
   logic [7:0]         core_rd, store_rd, rd_mux;

   assign sel_ptr  = ind_sel ? ptr1 : ptr0;
   assign dir_act  = !pm_pend_q && (dir_rd || dir_wr);
   assign ind_act  = !pm_pend_q && !dir_act && (ind_rd || ind_wr);
   assign ind_pm   = sel_ptr[PTR_W-1];
   assign in_range = dir_act || (sel_ptr[PTR_W-2:DA_W] == '0);
   assign addr     = dir_act ? {bsr, dir_addr} : sel_ptr[DA_W-1:0];
   assign acc_wr   = dir_act ? dir_wr : (ind_act && ind_wr && !ind_pm);
   assign acc_rd   = dir_act ? dir_rd : (ind_act && ind_rd && !ind_pm);
   assign pm_start = ind_act && ind_rd && ind_pm;

   dmx_decode #(
      .BANK_W(BANK_W), .PER_BANKS(PER_BANKS), .GPR_BANKS(GPR_BANKS)
   ) u_decode (
      .addr(addr), .in_range(in_range),
      .region(region), .idx(idx), .bank(bank)
   );

   dmx_core_regs #(.BANK_W(BANK_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_wr && region == RG_CORE),
      .idx(idx[3:0]), .wdata(wdata),
      .rd_data(core_rd), .bsr(bsr), .ptr0(ptr0), .ptr1(ptr1)
   );

   dmx_store #(
      .BANK_W(BANK_W), .PER_BANKS(PER_BANKS), .GPR_BANKS(GPR_BANKS)
   ) u_store (
      .clk(clk),
      .wr_en(acc_wr && region != RG_CORE && region != RG_NONE),
      .region(region), .idx(idx), .bank(bank), .wdata(wdata),
      .rd_data(store_rd)
   );

   always_comb begin
      case (region)
         RG_CORE:                    rd_mux = core_rd;
         RG_PERI, RG_GPR, RG_COMMON: rd_mux = store_rd;
         default:                    rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_pend_q   <= 1'b0;
         prog_addr_q <= '0;
         rdata_q     <= '0;
      end else begin
         pm_pend_q <= pm_start;
         if (pm_start) prog_addr_q <= sel_ptr[PROG_AW-1:0];
         if (pm_pend_q)   rdata_q <= prog_word[DATA_W-1:0];
         else if (acc_rd) rdata_q <= rd_mux;
      end
   end

   assign prog_addr = prog_addr_q;
   assign rdata     = rdata_q;
   assign stall     = pm_pend_q;

endmodule

// File: rtl/dmx_access_chk.sv
module dmx_access_chk
   import dmx_pkg::*;
#(
   parameter int BANK_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_rd,
   input logic              dir_wr,
   input logic              ind_rd,
   input logic              ind_wr,
   input logic              ind_sel,
   input logic              stall,
   input logic [7:0]        rdata,
   input logic [BANK_W-1:0] bsr,
   input logic [PTR_W-1:0]  ptr0,
   input logic [PTR_W-1:0]  ptr1,
   input region_e           region
);

   logic sel_pm;
   assign sel_pm = ind_sel ? ptr1[PTR_W-1] : ptr0[PTR_W-1];

   p_stall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   p_pm_read_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_rd && !stall && !dir_rd && !dir_wr && sel_pm) |=> stall);

   p_direct_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && (dir_rd || dir_wr)) |=> !stall);

   p_stall_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(bsr) && $stable(ptr0) && $stable(ptr1)));

   p_pm_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_wr && !ind_rd && !stall && !dir_rd && !dir_wr && sel_pm)
      |=> ($stable(bsr) && $stable(ptr0) && $stable(ptr1)));

   p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && dir_rd && region == RG_NONE) |=> (rdata == 8'h00));

   p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !dir_rd && !ind_rd) |=> $stable(rdata));

endmodule

bind dmx_access dmx_access_chk #(.BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .dir_rd(dir_rd), .dir_wr(dir_wr),
   .ind_rd(ind_rd), .ind_wr(ind_wr), .ind_sel(ind_sel),
   .stall(stall), .rdata(rdata),
   .bsr(bsr), .ptr0(ptr0), .ptr1(ptr1), .region(region)
);

// File: tb/dmx_access_bench.sv
module dmx_access_bench;

   localparam int PAW = 10;
   localparam int PDW = 14;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [6:0]     dir_addr = '0;
   logic           dir_rd = 1'b0, dir_wr = 1'b0;
   logic           ind_rd = 1'b0, ind_wr = 1'b0, ind_sel = 1'b0;
   logic [7:0]     wdata = '0;
   logic [PDW-1:0] prog_word;
   logic [PAW-1:0] prog_addr;
   logic [7:0]     rdata;
   logic           stall;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   function automatic logic [PDW-1:0] pw(input logic [PAW-1:0] a);
      return {a[3:0], a} ^ 14'h2A5B;
   endfunction

   assign prog_word = pw(prog_addr);

   dmx_access u_dmx_access (
      .clk(clk), .rst_n(rst_n),
      .dir_addr(dir_addr), .dir_rd(dir_rd), .dir_wr(dir_wr),
      .ind_rd(ind_rd), .ind_wr(ind_wr), .ind_sel(ind_sel),
      .wdata(wdata), .prog_word(prog_word),
      .prog_addr(prog_addr), .rdata(rdata), .stall(stall)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic dwr(input logic [6:0] a, input logic [7:0] d);
      @(negedge clk);
      dir_addr = a; wdata = d; dir_wr = 1'b1;
      @(negedge clk);
      dir_wr = 1'b0;
   endtask

   task automatic drd(input logic [6:0] a, output logic [7:0] d);
      @(negedge clk);
      dir_addr = a; dir_rd = 1'b1;
      @(negedge clk);
      dir_rd = 1'b0;
      d = rdata;
   endtask

   task automatic set_bank(input logic [7:0] b);
      dwr(7'h08, b);
   endtask

   task automatic set_ptr(input logic sel, input logic [15:0] v);
      dwr(sel ? 7'h06 : 7'h04, v[7:0]);
      dwr(sel ? 7'h07 : 7'h05, v[15:8]);
   endtask

   task automatic ird(input logic sel, output logic [7:0] d, output int stalls);
      @(negedge clk);
      ind_sel = sel; ind_rd = 1'b1;
      @(negedge clk);
      ind_rd = 1'b0;
      stalls = 0;
      while (stall) begin
         stalls++;
         @(negedge clk);
      end
      d = rdata;
   endtask

   task automatic iwr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      ind_sel = sel; wdata = d; ind_wr = 1'b1;
      @(negedge clk);
      ind_wr = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1", "rdata after reset", 16'(rdata), 16'h00);
      check("R1", "stall after reset", 16'(stall), 16'h0);
      drd(7'h08, d); check("R1", "bank select", 16'(d), 16'h00);
      drd(7'h05, d); check("R1", "pointer 0 high", 16'(d), 16'h00);
      drd(7'h07, d); check("R1", "pointer 1 high", 16'(d), 16'h00);
   endtask

   task automatic t_direct;
      logic [7:0] d;
      dwr(7'h20, 8'h5A);
      dwr(7'h6F, 8'hA5);
      drd(7'h20, d); check("R2", "bank0 0x20", 16'(d), 16'h5A);
      drd(7'h6F, d); check("R2", "bank0 0x6F", 16'(d), 16'hA5);
      repeat (3) @(negedge clk);
      check("R2", "rdata held while idle", 16'(rdata), 16'hA5);
   endtask

   task automatic t_mirror;
      logic [7:0] d;
      dwr(7'h0A, 8'h3C);
      set_bank(8'h02);
      drd(7'h0A, d); check("R3", "core reg seen from bank 2", 16'(d), 16'h3C);
      drd(7'h08, d); check("R3", "bank select readback", 16'(d), 16'h02);
      set_bank(8'hFF);
      drd(7'h08, d); check("R3", "bank select upper bits", 16'(d), 16'h1F);
      set_bank(8'h00);
      drd(7'h0A, d); check("R3", "core reg back in bank 0", 16'(d), 16'h3C);
   endtask

   task automatic t_common;
      logic [7:0] d;
      dwr(7'h75, 8'h99);
      set_bank(8'h03);
      drd(7'h75, d); check("R4", "common from bank 3", 16'(d), 16'h99);
      dwr(7'h7F, 8'h11);
      set_bank(8'h00);
      drd(7'h7F, d); check("R4", "common from bank 0", 16'(d), 16'h11);
   endtask

   task automatic t_banks;
      logic [7:0] d;
      set_bank(8'h01);
      dwr(7'h20, 8'h77);
      set_bank(8'h00);
      drd(7'h20, d); check("R5", "bank0 gpr not aliased", 16'(d), 16'h5A);
      set_bank(8'h05);
      dwr(7'h20, 8'h44);
      drd(7'h20, d); check("R5", "gpr bank 5 unimplemented", 16'(d), 16'h00);
      set_bank(8'h01);
      dwr(7'h0C, 8'h12);
      drd(7'h0C, d); check("R5", "peripheral bank 1 unimplemented", 16'(d), 16'h00);
      set_bank(8'h00);
      dwr(7'h0C, 8'h34);
      drd(7'h0C, d); check("R5", "peripheral bank 0", 16'(d), 16'h34);
   endtask

   task automatic t_bank_timing;
      logic [7:0] d;
      dwr(7'h21, 8'h00);
      @(negedge clk);
      dir_addr = 7'h08; wdata = 8'h01; dir_wr = 1'b1;
      @(negedge clk);
      dir_addr = 7'h21; wdata = 8'hC3;
      @(negedge clk);
      dir_wr = 1'b0;
      drd(7'h21, d); check("R10", "back-to-back write landed in bank 1", 16'(d), 16'hC3);
      set_bank(8'h00);
      drd(7'h21, d); check("R10", "bank 0 untouched", 16'(d), 16'h00);
   endtask

   task automatic t_indirect;
      logic [7:0] d;
      int s;
      set_ptr(1'b0, 16'h00A0);
      ird(1'b0, d, s);
      check("R6", "indirect bank1 0x20", 16'(d), 16'h77);
      check("R6", "no stall on data read", 16'(s), 16'h0);
      set_ptr(1'b1, 16'h1020);
      ird(1'b1, d, s); check("R6", "bits 14:12 set read zero", 16'(d), 16'h00);
      iwr(1'b1, 8'h55);
      set_ptr(1'b1, 16'h0020);
      ird(1'b1, d, s); check("R6", "out-of-range write dropped", 16'(d), 16'h5A);
      iwr(1'b1, 8'h66);
      drd(7'h20, d); check("R6", "indirect write visible directly", 16'(d), 16'h66);
   endtask

   task automatic t_prog;
      logic [7:0] d;
      int s;
      set_ptr(1'b0, 16'h8005);
      ird(1'b0, d, s);
      check("R7", "program word 0x005", 16'(d), 16'(pw(10'h005) & 14'hFF));
      check("R7", "single stall cycle", 16'(s), 16'h1);
      set_ptr(1'b1, 16'h8405);
      ird(1'b1, d, s);
      check("R7", "wrap to 0x005", 16'(d), 16'(pw(10'h005) & 14'hFF));
      set_ptr(1'b1, 16'hFFFF);
      ird(1'b1, d, s);
      check("R7", "top word 0x3FF", 16'(d), 16'(pw(10'h3FF) & 14'hFF));
   endtask

   task automatic t_prog_write;
      logic [7:0] d;
      set_ptr(1'b0, 16'h8020);
      iwr(1'b0, 8'h01);
      drd(7'h20, d); check("R8", "aliased gpr unchanged", 16'(d), 16'h66);
      drd(7'h05, d); check("R8", "pointer high unchanged", 16'(d), 16'h80);
   endtask

   task automatic t_stall_ignore;
      logic [7:0] d;
      set_ptr(1'b0, 16'h8003);
      @(negedge clk);
      ind_sel = 1'b0; ind_rd = 1'b1;
      @(negedge clk);
      ind_rd = 1'b0;
      check("R9", "stall raised", 16'(stall), 16'h1);
      dir_addr = 7'h20; wdata = 8'hEE; dir_wr = 1'b1;
      @(negedge clk);
      dir_wr = 1'b0;
      check("R9", "stall dropped", 16'(stall), 16'h0);
      check("R9", "program data after stall", 16'(rdata), 16'(pw(10'h003) & 14'hFF));
      drd(7'h20, d); check("R9", "write during stall ignored", 16'(d), 16'h66);
   endtask

   task automatic t_priority;
      set_ptr(1'b0, 16'h0020);
      @(negedge clk);
      dir_addr = 7'h7F; dir_rd = 1'b1; ind_sel = 1'b0; ind_rd = 1'b1;
      @(negedge clk);
      dir_rd = 1'b0; ind_rd = 1'b0;
      check("R11", "direct read wins", 16'(rdata), 16'h11);
      check("R11", "no stall", 16'(stall), 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_mirror();
      t_common();
      t_banks();
      t_bank_timing();
      t_indirect();
      t_prog();
      t_prog_write();
      t_stall_ignore();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule